// File: doc/BRIEF.md
# Clock Output Power-Down and Enable Controller

This block is the control logic of a two-output differential clock generator. It decides, cycle by cycle, whether each differential output pair runs, and it generates the gated waveform for both legs of each pair. It also controls a single-ended reference output that can be running, driven low or left high-impedance. The block never lets a differential output run before the PLL reports lock. It only starts or stops a pair while that pair's true leg is low, so no runt pulse appears on either leg.

The asynchronous pins pass through a synchronizer before they affect the gating. These are the power-good/power-down pin, the per-output enable pins and the PLL lock indication. The per-output register enable bits come from the local clock domain as plain inputs. On the first power-good assertion after reset, the block latches an address-select strap that picks the serial-bus address. A spread-select input is turned into a 2-bit code for the PLL. Each running output toggles once per clock, so it runs at half the clock rate.

Top module: `clkgen_pd_ctrl`

## Requirements
- R1: While synchronized power-good is low, every differential true leg and complement leg is low.
- R2: A differential pair runs only when power-good, its enable pin, its register enable bit and PLL lock are all asserted. While it runs, the true leg alternates high and low on every clock and the complement leg is its inverse.
- R3: With power-good high and PLL locked, a pair whose enable pin or register enable bit is deasserted holds both legs low, and the other pair keeps running.
- R4: From reset until power-good is first seen high, the reference output enable `ref_oe_o` is 0 (high-impedance).
- R5: After power-good has been seen high once, any later power-good low keeps `ref_oe_o` at 1 and drives `ref_o` to 0.
- R6: While power-good is high, the reference output toggles every clock, whatever the differential enables and PLL lock are.
- R7: The strap is sampled only at the first power-good assertion after reset. Strap 0 selects address 7'b1101000 (0x68) and strap 1 selects 7'b1101010 (0x6A). Later strap changes have no effect, and the address reads 0x68 before it is sampled.
- R8: While synchronized PLL lock is low, no differential true leg goes high.
- R9: The spread code is registered with one clock of latency. Select 2'b00 gives code 2'b00 (off), 2'b01 gives 2'b01 (-0.25%), and 2'b10 or 2'b11 gives 2'b10 (-0.5%).
- R10: A pair starts or stops only while its true leg is low. Neither leg is ever high for two consecutive clocks, and the two legs are never high together.
- R11: The first-assertion flag and the latched address are cleared only by `rst`, not by power-down cycles.
- R12: The asynchronous pins (power-good, enable pins, PLL lock) act through a 2-flop synchronizer. A change is not visible on the outputs after two clock edges and takes effect at the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-domain clock |
| rst | input | 1 | Synchronous active-high global reset |
| pwr_good_i | input | 1 | Asynchronous power-good (high) / power-down (low) |
| oe_pin_i | input | N_OUT | Asynchronous per-output enable pins |
| oe_reg_i | input | N_OUT | Per-output register enable bits |
| pll_lock_i | input | 1 | Asynchronous PLL lock indication |
| addr_strap_i | input | 1 | Static address-select strap |
| spread_sel_i | input | 2 | Spread selection |
| dif_t_o | output | N_OUT | True legs of the differential outputs |
| dif_c_o | output | N_OUT | Complement legs of the differential outputs |
| ref_o | output | 1 | Reference output level |
| ref_oe_o | output | 1 | Reference output drive enable (0 = high-impedance) |
| bus_addr_o | output | 7 | Selected 7-bit serial-bus address |
| pll_spread_o | output | 2 | Spread code to the PLL |

## Verification
A change on an asynchronous pin takes effect on the outputs at the third rising edge after it is driven. A change on a register enable bit takes effect at the first edge, and a change on the spread select also appears after one edge. The bench drives every input on the falling edge and samples on the falling edge. The synchronizer test samples exactly after the second and the third edge. All other checks either wait at least six cycles for the state to settle and then count levels over a window, or sample one edge after a change to spread select. A monitor running on every falling edge catches any two-cycle-wide pulse and any overlap of the two legs while enables are switched at either clock phase.

// File: rtl/clkgen_pd_pkg.sv
package clkgen_pd_pkg;
  localparam int ADDR_W = 7;
  localparam logic [ADDR_W-1:0] BUS_ADDR_LO = 7'b1101000;
  localparam logic [ADDR_W-1:0] BUS_ADDR_HI = 7'b1101010;

  typedef enum logic [1:0] {
    SPREAD_OFF  = 2'b00,
    SPREAD_QTR  = 2'b01,
    SPREAD_HALF = 2'b10
  } spread_code_e;

  function automatic spread_code_e map_spread(input logic [1:0] sel);
    case (sel)
      2'b00:   map_spread = SPREAD_OFF;
      2'b01:   map_spread = SPREAD_QTR;
      default: map_spread = SPREAD_HALF;
    endcase
  endfunction
endpackage

// File: rtl/clkgen_sync.sv
module clkgen_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/clkgen_dif_gate.sv
module clkgen_dif_gate (
  input  logic clk,
  input  logic rst,
  input  logic allow_i,
  output logic t_o,
  output logic c_o
);
  logic run_q, t_q, c_q;
  logic run_d, t_d;

  // Run state may change only while the true leg is low.
  always_comb begin
    run_d = t_q ? run_q : allow_i;
    t_d   = !t_q && allow_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      t_q   <= 1'b0;
      c_q   <= 1'b0;
    end else begin
      run_q <= run_d;
      t_q   <= t_d;
      c_q   <= !t_d && run_d;
    end
  end

  assign t_o = t_q;
  assign c_o = c_q;

  p_legs_excl_r10: assert property (@(posedge clk) disable iff (rst) !(t_q && c_q));
  p_t_single_r10:  assert property (@(posedge clk) disable iff (rst) t_q |=> !t_q);
  p_c_single_r10:  assert property (@(posedge clk) disable iff (rst) c_q |=> !c_q);
  p_start_ok_r2:   assert property (@(posedge clk) disable iff (rst) !t_q && !allow_i |=> !t_q);
endmodule

// File: rtl/clkgen_ref_ctrl.sv
module clkgen_ref_ctrl
  import clkgen_pd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pg_s_i,
  input  logic              strap_i,
  output logic              ref_o,
  output logic              ref_oe_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              seen_q, ref_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      ref_q  <= 1'b0;
      addr_q <= BUS_ADDR_LO;
    end else begin
      ref_q <= pg_s_i ? !ref_q : 1'b0;
      if (pg_s_i) seen_q <= 1'b1;
      if (pg_s_i && !seen_q) addr_q <= strap_i ? BUS_ADDR_HI : BUS_ADDR_LO;
    end
  end

  assign ref_o    = ref_q;
  assign ref_oe_o = seen_q;
  assign addr_o   = addr_q;

  p_seen_sticky_r11: assert property (@(posedge clk) disable iff (rst) seen_q |=> seen_q);
  p_addr_hold_r7:    assert property (@(posedge clk) disable iff (rst) seen_q |=> $stable(addr_q));
  p_ref_low_r5:      assert property (@(posedge clk) disable iff (rst) seen_q && !pg_s_i |=> !ref_q && seen_q);
  p_hiz_r4:          assert property (@(posedge clk) disable iff (rst) !seen_q |-> !ref_q);
endmodule

// File: rtl/clkgen_pd_ctrl.sv
module clkgen_pd_ctrl
  import clkgen_pd_pkg::*;
#(
  parameter int N_OUT       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_good_i,
  input  logic [N_OUT-1:0]  oe_pin_i,
  input  logic [N_OUT-1:0]  oe_reg_i,
  input  logic              pll_lock_i,
  input  logic              addr_strap_i,
  input  logic [1:0]        spread_sel_i,
  output logic [N_OUT-1:0]  dif_t_o,
  output logic [N_OUT-1:0]  dif_c_o,
  output logic              ref_o,
  output logic              ref_oe_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [1:0]        pll_spread_o
);
  localparam int SW = N_OUT + 2;

  logic [SW-1:0]    async_raw, async_s;
  logic             pg_s, lock_s;
  logic [N_OUT-1:0] oe_pin_s, allow;
  spread_code_e     spread_q;

  assign async_raw = {pll_lock_i, oe_pin_i, pwr_good_i};

  clkgen_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (async_raw),
    .q_o (async_s)
  );

  assign pg_s     = async_s[0];
  assign oe_pin_s = async_s[N_OUT:1];
  assign lock_s   = async_s[SW-1];

  genvar g;
  generate
    for (g = 0; g < N_OUT; g++) begin : g_dif
      assign allow[g] = pg_s && lock_s && oe_pin_s[g] && oe_reg_i[g];

      clkgen_dif_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .allow_i (allow[g]),
        .t_o     (dif_t_o[g]),
        .c_o     (dif_c_o[g])
      );
    end
  endgenerate

  clkgen_ref_ctrl u_ref (
    .clk      (clk),
    .rst      (rst),
    .pg_s_i   (pg_s),
    .strap_i  (addr_strap_i),
    .ref_o    (ref_o),
    .ref_oe_o (ref_oe_o),
    .addr_o   (bus_addr_o)
  );

  always_ff @(posedge clk) begin
    if (rst) spread_q <= SPREAD_OFF;
    else     spread_q <= map_spread(spread_sel_i);
  end

  assign pll_spread_o = spread_q;

  p_no_lock_r8: assert property (@(posedge clk) disable iff (rst) !lock_s |=> dif_t_o == '0);
  p_pg_low_r1:  assert property (@(posedge clk) disable iff (rst) !pg_s |=> dif_t_o == '0);
  p_spread_r9:  assert property (@(posedge clk) disable iff (rst) pll_spread_o != 2'b11);
endmodule

// File: tb/sim_clkgen_pd_ctrl.sv
module sim_clkgen_pd_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pg = 1'b0, lock = 1'b0, strap = 1'b0;
  logic [1:0] pin = 2'b00, regen = 2'b00, ssel = 2'b00;
  logic [1:0] t, c, sp;
  logic ro, roe;
  logic [6:0] addr;

  int n_run = 0, n_fail = 0, viol = 0;
  int th[2], ch[2], mism[2];
  int refh, refz;
  logic [1:0] pt = 2'b00, pc = 2'b00;

  always #2 clk = ~clk;

  clkgen_pd_ctrl u0 (
    .clk(clk), .rst(rst), .pwr_good_i(pg), .oe_pin_i(pin), .oe_reg_i(regen),
    .pll_lock_i(lock), .addr_strap_i(strap), .spread_sel_i(ssel),
    .dif_t_o(t), .dif_c_o(c), .ref_o(ro), .ref_oe_o(roe),
    .bus_addr_o(addr), .pll_spread_o(sp)
  );

  // R10 monitor: no leg high for two cycles, legs never high together
  always @(negedge clk) begin
    if (!rst) begin
      if ((t & pt) != 2'b00) viol++;
      if ((c & pc) != 2'b00) viol++;
      if ((t & c) != 2'b00) viol++;
    end
    pt = t;
    pc = c;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic window(input int n);
    for (int i = 0; i < 2; i++) begin th[i] = 0; ch[i] = 0; mism[i] = 0; end
    refh = 0; refz = 0;
    repeat (n) begin
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
        th[i] += int'(t[i]);
        ch[i] += int'(c[i]);
        if (c[i] != !t[i]) mism[i]++;
      end
      refh += int'(ro);
      if (!roe) refz++;
    end
  endtask

  task automatic t_reset;
    cyc(8);
    window(8);
    chk(th[0] + th[1] + ch[0] + ch[1] == 0, "R1", "legs high in reset/pd", th[0] + th[1] + ch[0] + ch[1], 0);
    chk(refz == 8, "R4", "ref hi-z cycles before pg", refz, 8);
    chk(addr == 7'h68, "R7", "address before sample", addr, 'h68);
  endtask

  task automatic t_no_lock;
    strap = 1'b1; pin = 2'b11; regen = 2'b11; pg = 1'b1;
    cyc(6);
    window(8);
    chk(th[0] + th[1] == 0, "R8", "true highs without lock", th[0] + th[1], 0);
    chk(refh == 4 && refz == 0, "R6", "ref highs while pg high", refh, 4);
    chk(addr == 7'h6A, "R7", "address with strap 1", addr, 'h6A);
  endtask

  task automatic t_sync;
    lock = 1'b1;
    cyc(2);
    chk(t == 2'b00, "R12", "true legs after two edges", t, 0);
    cyc(1);
    chk(t == 2'b11, "R12", "true legs after third edge", t, 3);
  endtask

  task automatic t_run;
    window(16);
    for (int i = 0; i < 2; i++) begin
      chk(th[i] == 8 && ch[i] == 8, "R2", "true/comp high count", th[i] * 100 + ch[i], 808);
      chk(mism[i] == 0, "R2", "complement mismatches", mism[i], 0);
    end
  endtask

  task automatic t_disable;
    pin[0] = 1'b0;
    cyc(6);
    window(8);
    chk(th[0] + ch[0] == 0, "R3", "out0 legs with pin off", th[0] + ch[0], 0);
    chk(th[1] == 4, "R3", "out1 still running", th[1], 4);
    pin[0] = 1'b1; regen[1] = 1'b0;
    cyc(6);
    window(8);
    chk(th[1] + ch[1] == 0, "R3", "out1 legs with reg bit off", th[1] + ch[1], 0);
    chk(th[0] == 4, "R3", "out0 running", th[0], 4);
    regen[1] = 1'b1;
    cyc(6);
  endtask

  task automatic t_glitch;
    for (int ph = 0; ph < 2; ph++) begin
      cyc(ph + 1);
      regen = 2'b00;
      cyc(6);
      regen = 2'b11;
      cyc(6);
      pin = 2'b00;
      cyc(ph + 5);
      pin = 2'b11;
      cyc(6);
    end
    chk(viol == 0, "R10", "runt or overlap events", viol, 0);
  endtask

  task automatic t_pdown;
    pg = 1'b0;
    cyc(6);
    window(8);
    chk(th[0] + th[1] + ch[0] + ch[1] == 0, "R1", "legs high at power-down", th[0] + th[1] + ch[0] + ch[1], 0);
    chk(refz == 0 && refh == 0, "R5", "ref hi-z or high cycles", refz * 100 + refh, 0);
    strap = 1'b0; pg = 1'b1;
    cyc(8);
    chk(addr == 7'h6A, "R11", "address after power cycle", addr, 'h6A);
    chk(roe == 1'b1, "R11", "ref drive kept", roe, 1);
  endtask

  task automatic t_spread;
    logic [1:0] exp_c [4];
    exp_c[0] = 2'b00; exp_c[1] = 2'b01; exp_c[2] = 2'b10; exp_c[3] = 2'b10;
    for (int s = 0; s < 4; s++) begin
      ssel = 2'(s);
      cyc(1);
      chk(sp == exp_c[s], "R9", "spread code", sp, exp_c[s]);
    end
  endtask

  task automatic t_rerst;
    rst = 1'b1; pg = 1'b0; strap = 1'b0;
    cyc(3);
    rst = 1'b0;
    cyc(2);
    chk(roe == 1'b0, "R4", "ref hi-z after reset", roe, 0);
    pg = 1'b1;
    cyc(6);
    chk(addr == 7'h68, "R7", "address with strap 0", addr, 'h68);
    chk(roe == 1'b1, "R11", "flag set again after reset", roe, 1);
  endtask

  initial begin
    fork
      begin
        cyc(3);
        rst = 1'b0;
        t_reset();
        t_no_lock();
        t_sync();
        t_run();
        t_disable();
        t_glitch();
        t_pdown();
        t_spread();
        t_rerst();
      end
      begin
        cyc(20000);
        chk(1'b0, "WDOG", "watchdog expired", 1, 0);
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule